// File: doc/BRIEF.md
# Escalating Per-Core Watchdog

This block holds one watchdog for each processor core. Software writes a length and a mode into a core's configuration, then must poke that core's watchdog regularly. A prescaler divides the clock. A down-counter, whose upper bits come from the length and whose low bits load as zero, steps once per prescaled tick. Each time that counter runs out, the watchdog climbs one stage. The stages are an interrupt, then a non-maskable interrupt, then a one-cycle soft-reset request.

The mode sets how far the escalation may climb. A poke sends the watchdog back to idle and starts a full new period. Writing an all-zero configuration switches a core's watchdog off. Software can select any core and read its live count, to see how much time remains before the next stage.

Top module: `wdt_escalate`

## Requirements
- R1: After reset every irq_o, nmi_o and srst_o bit is low and every core's count reads zero.
- R2: A write to core i (cfg_we[i] high) stores cfg_len and cfg_mode and loads the count with cfg_len in its upper LEN_W bits and zeros in the low CNT_W-LEN_W bits. The count of the core chosen by rd_sel appears on rd_count in the same cycle.
- R3: While a core runs, its count steps down by one once every 2**PRE_LOG2 clock cycles. The default of 8 gives 256 cycles; 9 and 10 give 512 and 1024. The prescaler restarts from zero on every configuration write and every poke.
- R4: When a tick arrives while the count is zero, the stage advances and the count reloads from the length. With C = len << (CNT_W-LEN_W) and P = 2**PRE_LOG2, each stage therefore lasts (C+1)*P cycles from the configuration write or poke.
- R5: In mode 3, irq_o rises after one period, nmi_o after a second period, and srst_o after a third period.
- R6: A stage beyond the mode is never entered: mode 1 stops at the interrupt and mode 2 at the NMI. In the last enabled stage the watchdog holds and its count stays frozen.
- R7: Mode 0 is off. No stage output is produced and the count holds its loaded value.
- R8: A poke (poke[i] high for one cycle) reloads core i's count from its length, clears its interrupt and NMI, and returns it to idle.
- R9: A poke in the same cycle as an expiry wins: no stage advance takes place and a full new period starts.
- R10: irq_o and nmi_o are levels that stay high until a poke or a configuration write. srst_o is high for exactly one cycle.
- R11: Cores are independent. A write or poke to one core leaves every other core's outputs and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | NUM_CORES | Per-core configuration write strobe |
| cfg_len | input | LEN_W | Length written by a configuration write |
| cfg_mode | input | 2 | Mode written by a configuration write (0 off, 1 irq, 2 irq+nmi, 3 irq+nmi+reset) |
| poke | input | NUM_CORES | Per-core service strobe |
| rd_sel | input | SEL_W | Core whose count is shown on rd_count |
| rd_count | output | CNT_W | Current count of the selected core |
| irq_o | output | NUM_CORES | Interrupt level per core |
| nmi_o | output | NUM_CORES | Non-maskable interrupt level per core |
| srst_o | output | NUM_CORES | One-cycle soft-reset request per core |

## Verification
The assertions assume that strobes are sampled only on clock edges and that cfg_mode holds a defined value whenever a write strobe is high. The stimulus drives every input on the falling edge and raises each strobe for exactly one cycle. It never writes and pokes the same core in the same cycle, so the outcome of each strobe can be attributed to it alone. A short prescaler and a narrow counter keep every escalation within a few dozen cycles, and a full escalation is observed cycle by cycle at each stage boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQ  = 2'd1,
        ST_NMI  = 2'd2,
        ST_RST  = 2'd3
    } stage_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam logic [PRE_LOG2-1:0] LAST = {PRE_LOG2{1'b1}};

    logic [PRE_LOG2-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr)
            pre_d = '0;
        else if (en)
            pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else
            pre_q <= pre_d;
    end

    assign tick = en && !clr && (pre_q == LAST);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke,
    input  logic             tick,
    output logic             run,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             nmi,
    output logic             srst
);
    localparam int LOW_W = CNT_W - LEN_W;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [1:0]       mode;
        logic [CNT_W-1:0] cnt;
        stage_e           stage;
        logic             srst;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     frozen;
    stage_e   next_stage;

    // The last stage the mode allows has the same code as the mode itself.
    assign frozen = (st_q.stage == stage_e'(st_q.mode));
    assign run    = (st_q.mode != 2'd0) && !frozen;

    always_comb begin
        case (st_q.stage)
            ST_IDLE: next_stage = ST_IRQ;
            ST_IRQ:  next_stage = ST_NMI;
            default: next_stage = ST_RST;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        if (cfg_we) begin
            st_d.len   = cfg_len;
            st_d.mode  = cfg_mode;
            st_d.cnt   = {cfg_len, {LOW_W{1'b0}}};
            st_d.stage = ST_IDLE;
        end else if (poke) begin
            st_d.cnt   = {st_q.len, {LOW_W{1'b0}}};
            st_d.stage = ST_IDLE;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.stage = next_stage;
                st_d.cnt   = {st_q.len, {LOW_W{1'b0}}};
                st_d.srst  = (next_stage == ST_RST);
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{len: '0, mode: 2'd0, cnt: '0, stage: ST_IDLE, srst: 1'b0};
        else
            st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign irq   = (st_q.stage != ST_IDLE);
    assign nmi   = (st_q.stage == ST_NMI) || (st_q.stage == ST_RST);
    assign srst  = st_q.srst;
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
    parameter int NUM_CORES = 2,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 24,
    parameter int PRE_LOG2  = 8,
    parameter int SEL_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] cfg_we,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [1:0]           cfg_mode,
    input  logic [NUM_CORES-1:0] poke,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [CNT_W-1:0]     rd_count,
    output logic [NUM_CORES-1:0] irq_o,
    output logic [NUM_CORES-1:0] nmi_o,
    output logic [NUM_CORES-1:0] srst_o
);
    logic [CNT_W-1:0] cnt_all [NUM_CORES];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic tick_c;
        logic run_c;

        wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) i_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cfg_we[c] | poke[c]),
            .en    (run_c),
            .tick  (tick_c)
        );

        wdt_core #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[c]),
            .cfg_len  (cfg_len),
            .cfg_mode (cfg_mode),
            .poke     (poke[c]),
            .tick     (tick_c),
            .run      (run_c),
            .count    (cnt_all[c]),
            .irq      (irq_o[c]),
            .nmi      (nmi_o[c]),
            .srst     (srst_o[c])
        );
    end

    always_comb begin
        rd_count = '0;
        for (int c = 0; c < NUM_CORES; c++)
            if (rd_sel == SEL_W'(c))
                rd_count = cnt_all[c];
    end
endmodule

// File: rtl/wdt_escalate_chk.sv
module wdt_escalate_chk #(
    parameter int NUM_CORES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] cfg_we,
    input logic [NUM_CORES-1:0] poke,
    input logic [NUM_CORES-1:0] irq_o,
    input logic [NUM_CORES-1:0] nmi_o,
    input logic [NUM_CORES-1:0] srst_o
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R5
        nmi_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nmi_o[c] |-> irq_o[c]);

        // R5
        nmi_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(nmi_o[c]) |-> $past(irq_o[c]));

        // R10
        srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            srst_o[c] |=> !srst_o[c]);

        // R5
        srst_needs_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            srst_o[c] |-> nmi_o[c]);

        // R8
        poke_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (poke[c] || cfg_we[c]) |=> (!irq_o[c] && !nmi_o[c] && !srst_o[c]));
    end
endmodule

bind wdt_escalate wdt_escalate_chk #(.NUM_CORES(NUM_CORES)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .poke   (poke),
    .irq_o  (irq_o),
    .nmi_o  (nmi_o),
    .srst_o (srst_o)
);

// File: tb/test_wdt_escalate.sv
module test_wdt_escalate;
    localparam int NC    = 2;
    localparam int LEN_W = 16;
    localparam int CNT_W = 18;
    localparam int PLOG  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    cfg_we = '0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [1:0]       cfg_mode = '0;
    logic [NC-1:0]    poke = '0;
    logic [0:0]       rd_sel = '0;
    logic [CNT_W-1:0] rd_count;
    logic [NC-1:0]    irq_o, nmi_o, srst_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdt_escalate #(.NUM_CORES(NC), .LEN_W(LEN_W), .CNT_W(CNT_W), .PRE_LOG2(PLOG)) i_wdt_escalate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_mode(cfg_mode),
        .poke(poke), .rd_sel(rd_sel), .rd_count(rd_count),
        .irq_o(irq_o), .nmi_o(nmi_o), .srst_o(srst_o)
    );

    typedef struct packed {
        logic [1:0]       mode;
        logic [15:0]      len;
        logic [7:0]       wait_n;
        logic             irq;
        logic             nmi;
        logic             srst;
        logic [CNT_W-1:0] cnt;
    } vec_t;

    // len=1 -> C=4, P=4, one stage lasts 20 cycles; len=2 -> 36 cycles
    localparam vec_t VECS [11] = '{
        '{2'd3, 16'd1, 8'd0,  1'b0, 1'b0, 1'b0, 18'd4},
        '{2'd3, 16'd1, 8'd6,  1'b0, 1'b0, 1'b0, 18'd3},
        '{2'd3, 16'd1, 8'd19, 1'b0, 1'b0, 1'b0, 18'd0},
        '{2'd3, 16'd1, 8'd20, 1'b1, 1'b0, 1'b0, 18'd4},
        '{2'd3, 16'd1, 8'd40, 1'b1, 1'b1, 1'b0, 18'd4},
        '{2'd3, 16'd1, 8'd60, 1'b1, 1'b1, 1'b1, 18'd4},
        '{2'd3, 16'd1, 8'd61, 1'b1, 1'b1, 1'b0, 18'd4},
        '{2'd1, 16'd1, 8'd60, 1'b1, 1'b0, 1'b0, 18'd4},
        '{2'd2, 16'd1, 8'd80, 1'b1, 1'b1, 1'b0, 18'd4},
        '{2'd0, 16'd1, 8'd80, 1'b0, 1'b0, 1'b0, 18'd4},
        '{2'd2, 16'd2, 8'd35, 1'b0, 1'b0, 1'b0, 18'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cfg(input int c, input logic [1:0] m, input logic [15:0] l);
        cfg_we[c] = 1'b1;
        cfg_mode  = m;
        cfg_len   = l;
        @(negedge clk);
        cfg_we = '0;
    endtask

    task automatic do_poke(input int c);
        poke[c] = 1'b1;
        @(negedge clk);
        poke = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 nmi", 32'(nmi_o), 0);
        chk("R1 srst", 32'(srst_o), 0);
        chk("R1 count", 32'(rd_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: R2 R3 R4 R5 R6 R7 R10
        for (int v = 0; v < 11; v++) begin
            do_cfg(0, VECS[v].mode, VECS[v].len);
            repeat (int'(VECS[v].wait_n)) @(negedge clk);
            chk($sformatf("R5/R6 irq vec%0d", v), 32'(irq_o[0]), 32'(VECS[v].irq));
            chk($sformatf("R5/R6 nmi vec%0d", v), 32'(nmi_o[0]), 32'(VECS[v].nmi));
            chk($sformatf("R10 srst vec%0d", v), 32'(srst_o[0]), 32'(VECS[v].srst));
            chk($sformatf("R2/R3/R4 count vec%0d", v), 32'(rd_count), 32'(VECS[v].cnt));
        end
        // R4 boundary at 36 cycles for len=2
        do_cfg(0, 2'd2, 16'd2);
        repeat (36) @(negedge clk);
        chk("R4 irq at len2 boundary", 32'(irq_o[0]), 1);
        chk("R4 reload len2", 32'(rd_count), 8);

        // R8 poke clears irq and nmi
        do_cfg(0, 2'd3, 16'd1);
        repeat (45) @(negedge clk);
        chk("R10 nmi held", 32'(nmi_o[0]), 1);
        do_poke(0);
        chk("R8 irq cleared", 32'(irq_o[0]), 0);
        chk("R8 nmi cleared", 32'(nmi_o[0]), 0);
        chk("R8 count reload", 32'(rd_count), 4);

        // R9 poke on the expiry edge wins
        do_cfg(0, 2'd3, 16'd1);
        repeat (19) @(negedge clk);
        do_poke(0);
        chk("R9 no advance", 32'(irq_o[0]), 0);
        chk("R9 count reload", 32'(rd_count), 4);
        repeat (19) @(negedge clk);
        chk("R9 new period not yet", 32'(irq_o[0]), 0);
        @(negedge clk);
        chk("R9 new period expires", 32'(irq_o[0]), 1);

        // R11 independence
        do_cfg(1, 2'd1, 16'd1);
        repeat (25) @(negedge clk);
        chk("R11 core1 irq", 32'(irq_o[1]), 1);
        do_poke(0);
        chk("R11 core1 irq kept", 32'(irq_o[1]), 1);
        chk("R11 core0 irq cleared", 32'(irq_o[0]), 0);
        rd_sel = 1'b1;
        #1;
        chk("R11 core1 count", 32'(rd_count), 4);

        // R7 disable by zero write
        do_cfg(1, 2'd0, 16'd0);
        chk("R7 irq off", 32'(irq_o[1]), 0);
        repeat (50) @(negedge clk);
        chk("R7 stays off", 32'(irq_o[1] | nmi_o[1] | srst_o[1]), 0);
        chk("R7 count held", 32'(rd_count), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule